// File: doc/BRIEF.md
# Prescaled Capture Timebase Counter

This block is the free-running time reference of an input-capture unit. A 24-bit register counts upward, one step per timebase tick. The tick comes either from a pre-divider in front of the system clock, with eight ratios from 1 to 128, or from the rising edges of one of three capture input levels. The live count is what the capture channels sample when an edge arrives.

Around the count sit four event paths. A compare path flags the step that brings the count to a programmed value. An overflow path flags the wrap from all ones to zero. A reload path loads the compare value into the count on a chosen channel event or on overflow. A clear path zeroes the count on a compare match or on any capture event. When these land in the same clock cycle, reload takes precedence over clear, and clear takes precedence over the step. Every input is sampled on the rising clock edge, and the count and both event pulses come from registers.

Top module: `tbase_timer`

## Requirements
- R1: While `rst` is high at a clock edge, `count` becomes 0 and `cmp_evt` and `ovf_evt` become 0.
- R2: With `src_sel` = 0, `div_code` values 0 to 7 select tick ratios 1, 4, 16, 32, 64, 96, 112 and 128. After `start` and `enable` rise with the code settled, the count reaches 1 at the N-th clock edge and 2 at the 2N-th.
- R3: While `start` is 0 the count holds its value. While `enable` is 0 the count holds its value, and capture events, reload and clear have no effect.
- R4: With `src_sel` = 1, 2 or 3, the count steps once per rising edge of `cap_in[0]`, `cap_in[1]` or `cap_in[2]`. The new value is visible after the third clock edge following the input change. Edges on unselected inputs do not step the count.
- R5: With `cmp_en` = 1, a step that makes the count equal to `cmp_val` drives `cmp_evt` high for one cycle. That cycle is the one in which `count` first shows the result of the step. With `cmp_en` = 0, no compare pulse is produced and no compare clear occurs.
- R6: A step taken from 0xFFFFFF wraps the count to 0 and drives `ovf_evt` high for one cycle, in the cycle the wrapped value is shown.
- R7: With `cmp_clr_en` = 1, the step that matches `cmp_val` loads 0 instead of the matched value. The count therefore runs 1 up to `cmp_val`-1 and then 0.
- R8: With `cap_clr_en` = 1, a pulse on any bit of `cap_evt` sets the count to 0 at that edge.
- R9: With `rld_en` = 1, the trigger chosen by `rld_src` loads `cmp_val` into the count. Code 000 selects `cap_evt[0]`, 001 selects `cap_evt[1]`, 010 selects `cap_evt[2]` and 100 selects overflow. Codes 011, 101, 110 and 111 never reload.
- R10: In one cycle, reload wins over clear and clear wins over a step.
- R11: The pre-divider restarts its phase when `div_code` changes or when `start` or `enable` is low. After a restart, the next tick comes a full N edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Unit enable; low freezes the count and ignores events |
| start | input | 1 | Counting run control |
| div_code | input | 3 | Pre-divider ratio code |
| src_sel | input | 2 | Tick source: 0 divider, 1..3 capture input 0..2 |
| cap_in | input | 3 | Raw capture input levels usable as tick source |
| cap_evt | input | 3 | Single-cycle capture event pulses per channel |
| cmp_en | input | 1 | Compare detection enable |
| cmp_clr_en | input | 1 | Clear on compare match |
| cap_clr_en | input | 1 | Clear on any capture event |
| rld_en | input | 1 | Reload enable |
| rld_src | input | 3 | Reload trigger select code |
| cmp_val | input | 24 | Compare and reload value |
| count | output | 24 | Live count |
| cmp_evt | output | 1 | Compare-match pulse |
| ovf_evt | output | 1 | Overflow pulse |

## Verification
Some properties are checked on every cycle. The count stays frozen while the unit is disabled. An overflow pulse only follows an all-ones count. A compare pulse only follows an enabled compare. A reload or clear lands its value on the next edge. Synchronized edges and divided ticks never repeat on consecutive cycles. Other behaviour only the scenarios can show, because it depends on exact cycle positions over long spans: the tick ratio for each divider code, phase restart after a code change or a stop, the three-edge latency of the capture source, the decoding of the reload codes (including the unused ones), and the wrap period under compare-clear.

// File: rtl/tbase_pkg.sv
package tbase_pkg;

  localparam int DIVC_W = 3;
  localparam int PRE_W  = 8;
  localparam int RLS_W  = 3;

  localparam logic [RLS_W-1:0] RLS_OVF = 3'b100;

  typedef struct packed {
    logic reload;
    logic clear;
    logic step;
  } upd_t;

  function automatic logic [PRE_W-1:0] div_ratio(input logic [DIVC_W-1:0] code);
    case (code)
      3'd0:    div_ratio = 8'd1;
      3'd1:    div_ratio = 8'd4;
      3'd2:    div_ratio = 8'd16;
      3'd3:    div_ratio = 8'd32;
      3'd4:    div_ratio = 8'd64;
      3'd5:    div_ratio = 8'd96;
      3'd6:    div_ratio = 8'd112;
      default: div_ratio = 8'd128;
    endcase
  endfunction

endpackage

// File: rtl/tbase_prescale.sv
module tbase_prescale
  import tbase_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [DIVC_W-1:0] code,
  output logic              tick
);

  logic [PRE_W-1:0]  phase;
  logic [PRE_W-1:0]  last;
  logic [DIVC_W-1:0] code_q;
  logic              restart;

  assign last    = div_ratio(code) - PRE_W'(1);
  assign restart = !run || (code != code_q);
  assign tick    = !restart && (phase == last);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase  <= '0;
      code_q <= '0;
    end else begin
      code_q <= code;
      if (restart || phase == last) phase <= '0;
      else                          phase <= phase + PRE_W'(1);
    end
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    (tick && last != '0) |=> !tick); // R2

endmodule

// File: rtl/tbase_edge_sync.sv
module tbase_edge_sync #(
  parameter int CH    = 3,
  parameter int SYNC  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CH-1:0] din,
  output logic [CH-1:0] rise
);

  localparam int SH_W = SYNC + 1;

  for (genvar i = 0; i < CH; i++) begin : g_ch
    logic [SH_W-1:0] sh;

    always_ff @(posedge clk) begin
      if (rst) sh <= '0;
      else     sh <= {sh[SH_W-2:0], din[i]};
    end

    assign rise[i] = sh[SH_W-2] & ~sh[SH_W-1];

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
      rise[i] |=> !rise[i]); // R4
  end

endmodule

// File: rtl/tbase_core.sv
module tbase_core
  import tbase_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CH    = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             start,
  input  logic             tick,
  input  logic             cmp_en,
  input  logic             cmp_clr_en,
  input  logic             cap_clr_en,
  input  logic             rld_en,
  input  logic [RLS_W-1:0] rld_src,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic [CH-1:0]    cap_evt,
  output logic [CNT_W-1:0] count,
  output logic             cmp_evt,
  output logic             ovf_evt
);

  logic [CNT_W-1:0] count_q;
  logic [CNT_W-1:0] cnt_inc;
  logic             cmp_q;
  logic             ovf_q;
  logic             ovf_hit;
  logic             cmp_hit;
  logic             rl_trig;
  upd_t             upd;

  assign cnt_inc = count_q + CNT_W'(1);
  assign ovf_hit = upd.step && (&count_q);
  assign cmp_hit = upd.step && cmp_en && (cnt_inc == cmp_val);

  always_comb begin
    rl_trig = 1'b0;
    if (rld_src == RLS_OVF) rl_trig = ovf_hit;
    for (int c = 0; c < CH; c++) begin
      if (rld_src == RLS_W'(c)) rl_trig = cap_evt[c];
    end
  end

  always_comb begin
    upd.step   = enable && start && tick;
    upd.reload = enable && rld_en && rl_trig;
    upd.clear  = enable && ((cmp_clr_en && cmp_hit) || (cap_clr_en && (|cap_evt)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count_q <= '0;
      cmp_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (upd.reload)     count_q <= cmp_val;
      else if (upd.clear) count_q <= '0;
      else if (upd.step)  count_q <= cnt_inc;
      cmp_q <= cmp_hit;
      ovf_q <= ovf_hit;
    end
  end

  assign count   = count_q;
  assign cmp_evt = cmp_q;
  assign ovf_evt = ovf_q;

  AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
    !enable |=> $stable(count_q)); // R3
  AST_OVF_FROM_MAX: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> (&$past(count_q))); // R6
  AST_CMP_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    cmp_q |-> $past(cmp_en)); // R5
  AST_RELOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    upd.reload |=> count_q == $past(cmp_val)); // R10
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (upd.clear && !upd.reload) |=> count_q == '0); // R8

endmodule

// File: rtl/tbase_timer.sv
module tbase_timer
  import tbase_pkg::*;
#(
  parameter int CNT_W = 24,
  parameter int CH    = 3,
  parameter int SYNC  = 2,
  localparam int SRC_W = $clog2(CH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              start,
  input  logic [DIVC_W-1:0] div_code,
  input  logic [SRC_W-1:0]  src_sel,
  input  logic [CH-1:0]     cap_in,
  input  logic [CH-1:0]     cap_evt,
  input  logic              cmp_en,
  input  logic              cmp_clr_en,
  input  logic              cap_clr_en,
  input  logic              rld_en,
  input  logic [RLS_W-1:0]  rld_src,
  input  logic [CNT_W-1:0]  cmp_val,
  output logic [CNT_W-1:0]  count,
  output logic              cmp_evt,
  output logic              ovf_evt
);

  logic          pre_tick;
  logic [CH-1:0] rise;
  logic          tick;

  tbase_prescale u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (enable && start),
    .code (div_code),
    .tick (pre_tick)
  );

  tbase_edge_sync #(.CH(CH), .SYNC(SYNC)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (cap_in),
    .rise (rise)
  );

  always_comb begin
    tick = 1'b0;
    if (src_sel == SRC_W'(0)) tick = pre_tick;
    for (int c = 0; c < CH; c++) begin
      if (src_sel == SRC_W'(c + 1)) tick = rise[c];
    end
  end

  tbase_core #(.CNT_W(CNT_W), .CH(CH)) u_core (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .start      (start),
    .tick       (tick),
    .cmp_en     (cmp_en),
    .cmp_clr_en (cmp_clr_en),
    .cap_clr_en (cap_clr_en),
    .rld_en     (rld_en),
    .rld_src    (rld_src),
    .cmp_val    (cmp_val),
    .cap_evt    (cap_evt),
    .count      (count),
    .cmp_evt    (cmp_evt),
    .ovf_evt    (ovf_evt)
  );

endmodule

// File: tb/tbase_timer_test.sv
module tbase_timer_test;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst;
  logic        enable, start;
  logic [2:0]  div_code;
  logic [1:0]  src_sel;
  logic [2:0]  cap_in, cap_evt;
  logic        cmp_en, cmp_clr_en, cap_clr_en, rld_en;
  logic [2:0]  rld_src;
  logic [23:0] cmp_val;
  logic [23:0] count;
  logic        cmp_evt, ovf_evt;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  tbase_timer uut (
    .clk(clk), .rst(rst), .enable(enable), .start(start), .div_code(div_code),
    .src_sel(src_sel), .cap_in(cap_in), .cap_evt(cap_evt), .cmp_en(cmp_en),
    .cmp_clr_en(cmp_clr_en), .cap_clr_en(cap_clr_en), .rld_en(rld_en),
    .rld_src(rld_src), .cmp_val(cmp_val), .count(count), .cmp_evt(cmp_evt),
    .ovf_evt(ovf_evt)
  );

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int ratio(input int code);
    case (code)
      0: return 1;
      1: return 4;
      2: return 16;
      3: return 32;
      4: return 64;
      5: return 96;
      6: return 112;
      default: return 128;
    endcase
  endfunction

  task automatic do_reset();
    rst = 1'b1; enable = 1'b1; start = 1'b0; div_code = 3'd0; src_sel = 2'd0;
    cap_in = 3'b000; cap_evt = 3'b000; cmp_en = 1'b0; cmp_clr_en = 1'b0;
    cap_clr_en = 1'b0; rld_en = 1'b0; rld_src = 3'b000; cmp_val = 24'h0;
    step(3);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    start = 1'b1; cmp_en = 1'b1; cmp_val = 24'd2;
    step(4);
    rst = 1'b1;
    step(1);
    chk("R1 count", 32'(count), 32'h0);
    chk("R1 cmp_evt", 32'(cmp_evt), 32'h0);
    chk("R1 ovf_evt", 32'(ovf_evt), 32'h0);
    rst = 1'b0;
  endtask

  task automatic t_divider();
    for (int code = 0; code < 8; code++) begin
      do_reset();
      div_code = 3'(code);
      step(1);
      start = 1'b1;
      step(2 * ratio(code) - 1);
      chk($sformatf("R2 code%0d first", code), 32'(count), 32'd1);
      step(1);
      chk($sformatf("R2 code%0d second", code), 32'(count), 32'd2);
    end
  endtask

  task automatic t_restart();
    do_reset();
    div_code = 3'd3;
    step(1);
    start = 1'b1;
    step(20);
    chk("R11 before change", 32'(count), 32'd0);
    div_code = 3'd2;
    step(16);
    chk("R11 after change early", 32'(count), 32'd0);
    step(1);
    chk("R11 after change tick", 32'(count), 32'd1);
    step(5);
    start = 1'b0;
    step(1);
    start = 1'b1;
    step(15);
    chk("R11 after stop early", 32'(count), 32'd1);
    step(1);
    chk("R11 after stop tick", 32'(count), 32'd2);
  endtask

  task automatic t_hold();
    do_reset();
    start = 1'b1;
    step(5);
    chk("R3 running", 32'(count), 32'd5);
    start = 1'b0;
    step(4);
    chk("R3 start low holds", 32'(count), 32'd5);
    start = 1'b1; enable = 1'b0;
    cap_clr_en = 1'b1; rld_en = 1'b1; rld_src = 3'b000; cmp_val = 24'd77;
    step(2);
    cap_evt = 3'b001;
    step(1);
    cap_evt = 3'b000;
    step(1);
    chk("R3 disabled ignores events", 32'(count), 32'd5);
    cap_clr_en = 1'b0; rld_en = 1'b0; enable = 1'b1;
    step(1);
    chk("R3 resumes", 32'(count), 32'd6);
  endtask

  task automatic t_source();
    do_reset();
    src_sel = 2'd2; start = 1'b1;
    cap_in[1] = 1'b1;
    step(2);
    chk("R4 latency early", 32'(count), 32'd0);
    step(1);
    chk("R4 latency edge", 32'(count), 32'd1);
    cap_in[1] = 1'b0;
    step(3);
    for (int k = 0; k < 4; k++) begin
      cap_in[1] = 1'b1; cap_in[0] = ~cap_in[0];
      step(3);
      cap_in[1] = 1'b0;
      step(3);
    end
    step(3);
    chk("R4 selected input edges", 32'(count), 32'd5);
    src_sel = 2'd3;
    cap_in[1] = 1'b1;
    step(4);
    cap_in[1] = 1'b0;
    step(4);
    chk("R4 unselected ignored", 32'(count), 32'd5);
    cap_in[2] = 1'b1;
    step(3);
    chk("R4 input2 edge", 32'(count), 32'd6);
  endtask

  task automatic t_compare();
    do_reset();
    cmp_val = 24'd5; cmp_en = 1'b1; start = 1'b1;
    step(5);
    chk("R5 match count", 32'(count), 32'd5);
    chk("R5 match pulse", 32'(cmp_evt), 32'd1);
    step(1);
    chk("R5 pulse ends", 32'(cmp_evt), 32'd0);
    chk("R5 count continues", 32'(count), 32'd6);
    do_reset();
    cmp_val = 24'd3; cmp_en = 1'b0; cmp_clr_en = 1'b1; start = 1'b1;
    step(3);
    chk("R5 disabled no pulse", 32'(cmp_evt), 32'd0);
    step(1);
    chk("R5 disabled no clear", 32'(count), 32'd4);
  endtask

  task automatic t_cmpclr();
    do_reset();
    cmp_val = 24'd4; cmp_en = 1'b1; cmp_clr_en = 1'b1; start = 1'b1;
    step(3);
    chk("R7 before match", 32'(count), 32'd3);
    step(1);
    chk("R7 cleared", 32'(count), 32'd0);
    chk("R7 pulse", 32'(cmp_evt), 32'd1);
    step(4);
    chk("R7 period", 32'(count), 32'd0);
    chk("R7 second pulse", 32'(cmp_evt), 32'd1);
    step(1);
    chk("R7 restart", 32'(count), 32'd1);
  endtask

  task automatic t_overflow();
    do_reset();
    rld_en = 1'b1; rld_src = 3'b000; cmp_val = 24'hFFFFFD;
    cap_evt = 3'b001;
    step(1);
    cap_evt = 3'b000;
    chk("R9 channel0 reload", 32'(count), 32'hFFFFFD);
    start = 1'b1;
    step(2);
    chk("R6 at max", 32'(count), 32'hFFFFFF);
    chk("R6 no early pulse", 32'(ovf_evt), 32'd0);
    step(1);
    chk("R6 wrapped", 32'(count), 32'h0);
    chk("R6 pulse", 32'(ovf_evt), 32'd1);
    step(1);
    chk("R6 pulse ends", 32'(ovf_evt), 32'd0);
    start = 1'b0; cmp_val = 24'hFFFFFE;
    cap_evt = 3'b001;
    step(1);
    cap_evt = 3'b000; rld_src = 3'b100; start = 1'b1;
    step(1);
    chk("R9 ovf setup", 32'(count), 32'hFFFFFF);
    step(1);
    chk("R9 overflow reload", 32'(count), 32'hFFFFFE);
    chk("R6 pulse on reload", 32'(ovf_evt), 32'd1);
  endtask

  task automatic t_reload_codes();
    do_reset();
    rld_en = 1'b1; cmp_val = 24'h000123; rld_src = 3'b001;
    cap_evt = 3'b001;
    step(1);
    cap_evt = 3'b000;
    chk("R9 other channel ignored", 32'(count), 32'h0);
    cap_evt = 3'b010;
    step(1);
    cap_evt = 3'b000;
    chk("R9 channel1 reload", 32'(count), 32'h123);
    cmp_val = 24'h000456;
    for (int code = 3; code < 8; code++) begin
      if (code != 4) begin
        rld_src = 3'(code);
        cap_evt = 3'b111;
        step(1);
        cap_evt = 3'b000;
        chk($sformatf("R9 unused code %0d", code), 32'(count), 32'h123);
      end
    end
    rld_src = 3'b010; cap_evt = 3'b100;
    step(1);
    cap_evt = 3'b000;
    chk("R9 channel2 reload", 32'(count), 32'h456);
    rld_en = 1'b0; rld_src = 3'b000; cmp_val = 24'h000789; cap_evt = 3'b001;
    step(1);
    cap_evt = 3'b000;
    chk("R9 reload disabled", 32'(count), 32'h456);
  endtask

  task automatic t_capclr();
    do_reset();
    start = 1'b1; cap_clr_en = 1'b1;
    step(6);
    chk("R8 running", 32'(count), 32'd6);
    cap_evt = 3'b100;
    step(1);
    cap_evt = 3'b000;
    chk("R10 clear beats step", 32'(count), 32'd0);
    step(1);
    chk("R8 resumes", 32'(count), 32'd1);
    rld_en = 1'b1; rld_src = 3'b000; cmp_val = 24'h50;
    cap_evt = 3'b001;
    step(1);
    cap_evt = 3'b000;
    chk("R10 reload beats clear", 32'(count), 32'h50);
    cap_evt = 3'b010;
    step(1);
    cap_evt = 3'b000;
    chk("R8 clear on channel1", 32'(count), 32'h0);
  endtask

  initial begin
    t_reset();
    t_divider();
    t_restart();
    t_hold();
    t_source();
    t_compare();
    t_cmpclr();
    t_overflow();
    t_reload_codes();
    t_capclr();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule